// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the 32-bit status and mode word of a floating-point unit. Each time an instruction finishes, the arithmetic datapath presents one flag per exception it detected. The block turns those flags into a 3-bit trap-type code and updates two sticky flags. It also raises a one-cycle trap request that the slave-protocol logic copies into its status word. Software-visible mode bits live in the same word: the rounding mode, which goes straight out to the datapath, and two trap enables.

A register-load command replaces the writable bits with a 32-bit value. A completed register-transfer instruction (load or store of this word) never disturbs the trap-type field. Bits 15:9 are a software field: they are stored and read back and have no effect on the hardware. The bits above the software field always read as zero.

Field layout, which the trap logic and the datapath depend on: trap type 2:0, underflow trap enable 3, underflow flag 4, inexact trap enable 5, inexact flag 6, rounding mode 8:7, software field 15:9.

Top module: `fp_status_reg`

## Requirements
- R1: An active-low reset `rstN` forces all 32 bits of `statusReg` to zero and holds `trapReq` low.
- R2: When `loadEn` is high at a clock edge, bits 15:0 of `statusReg` take `loadData[15:0]` and bits 31:16 stay zero. A load in the same cycle as `instDone` takes precedence, and the exception flags are ignored.
- R3: One clock after `instDone` with `isXfer` low, bits 2:0 hold the code of the highest-priority exception present. Priority runs illegal (100), then invalid (101), divide by zero (011), overflow (010), underflow (001), and inexact (110) last.
- R4: A completed instruction with no exception writes trap type 000. A completed transfer instruction (`isXfer` high) leaves the whole register unchanged and requests no trap, whatever flags are present.
- R5: Underflow sets bit 4 whether or not bit 3 (underflow enable) is set. Bit 4 stays set until a load writes it to zero or reset occurs.
- R6: Inexact sets bit 6 only when no other exception is present in the same instruction, and leaves bit 6 unchanged otherwise. Bit 6 is sticky in the same way as bit 4.
- R7: `trapReq` is high for exactly the cycle after a completed non-transfer instruction that reports overflow, divide by zero, invalid or illegal, regardless of the enable bits.
- R8: Underflow raises `trapReq` only when bit 3 is set. Inexact raises it only when bit 5 is set and no other exception is present. Otherwise `trapReq` stays low.
- R9: `roundMode` equals bits 8:7 (00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity) and changes only through a load or reset.
- R10: Bits 15:9 return exactly what was loaded. They are not altered by instruction completions and have no effect on trap requests or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instDone | input | 1 | An instruction completed this cycle |
| isXfer | input | 1 | The completed instruction is a load or store of this register |
| excIllegal | input | 1 | Illegal instruction form detected |
| excInvalid | input | 1 | Invalid operation detected |
| excDivZero | input | 1 | Non-zero value divided by zero |
| excOverflow | input | 1 | Result too large for the destination |
| excUnderflow | input | 1 | Non-zero result too small for a normalized value |
| excInexact | input | 1 | Result required rounding |
| loadEn | input | 1 | Write `loadData` into the register |
| loadData | input | 32 | Value for a register load |
| statusReg | output | 32 | Stored status and mode word |
| roundMode | output | 2 | Current rounding mode |
| trapReq | output | 1 | One-cycle trap request for the protocol status word |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 7-bit software field. With these values the zero-filled span 31:16 is present, so loads that carry ones in the top half show whether the mask holds. The software field at its full width reaches the bit-15 edge of the writable region. The scenarios pair each exception with both enable settings and combine exceptions to walk the priority order. They also apply a load together with a completion, send a transfer completion with flags raised, and apply a reset mid-run after the sticky flags have been set.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

  // Field positions; the trap logic and the datapath decode these
  localparam int TT_LSB    = 0;
  localparam int TT_MSB    = 2;
  localparam int UEN_BIT   = 3;
  localparam int UFLAG_BIT = 4;
  localparam int IEN_BIT   = 5;
  localparam int IFLAG_BIT = 6;
  localparam int RM_LSB    = 7;
  localparam int RM_MSB    = 8;
  localparam int SWF_LSB   = 9;

  typedef enum logic [2:0] {
    TRAP_NONE     = 3'b000,
    TRAP_UNDER    = 3'b001,
    TRAP_OVER     = 3'b010,
    TRAP_DIVZERO  = 3'b011,
    TRAP_ILLEGAL  = 3'b100,
    TRAP_INVALID  = 3'b101,
    TRAP_INEXACT  = 3'b110
  } trapCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadAll;
    logic      writeCode;
    trapCode_e code;
    logic      setUnder;
    logic      setInexact;
    logic      trap;
  } fsrStrobe_t;

endpackage

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
(
  input  logic       instDone,
  input  logic       isXfer,
  input  logic       loadEn,
  input  logic       excIllegal,
  input  logic       excInvalid,
  input  logic       excDivZero,
  input  logic       excOverflow,
  input  logic       excUnderflow,
  input  logic       excInexact,
  input  logic       underEn,
  input  logic       inexEn,
  output fsrStrobe_t stb
);

  logic      arithDone;
  logic      hardErr;
  logic      anyOther;
  logic      inexAlone;
  trapCode_e code;

  // Only non-transfer completions touch status; a load overrides them
  assign arithDone = instDone & ~isXfer & ~loadEn;
  assign hardErr   = excIllegal | excInvalid | excDivZero | excOverflow;
  assign anyOther  = hardErr | excUnderflow;
  assign inexAlone = excInexact & ~anyOther;

  // Priority: illegal, invalid, divide by zero, overflow, underflow, inexact
  always_comb begin
    if (excIllegal)        code = TRAP_ILLEGAL;
    else if (excInvalid)   code = TRAP_INVALID;
    else if (excDivZero)   code = TRAP_DIVZERO;
    else if (excOverflow)  code = TRAP_OVER;
    else if (excUnderflow) code = TRAP_UNDER;
    else if (excInexact)   code = TRAP_INEXACT;
    else                   code = TRAP_NONE;
  end

  always_comb begin
    stb            = '0;
    stb.loadAll    = loadEn;
    stb.writeCode  = arithDone;
    stb.code       = code;
    stb.setUnder   = arithDone & excUnderflow;
    stb.setInexact = arithDone & inexAlone;
    stb.trap       = arithDone & (hardErr
                                  | (excUnderflow & underEn)
                                  | (inexAlone & inexEn));
  end

endmodule

// File: rtl/fp_status_dp.sv
module fp_status_dp
  import fp_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SWF_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsrStrobe_t        stb,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] statusReg,
  output logic [1:0]        roundMode,
  output logic              underEn,
  output logic              inexEn,
  output logic              trapReq
);

  localparam int USED_W = SWF_LSB + SWF_W;
  localparam logic [DATA_W-1:0] LOAD_MASK = DATA_W'((64'd1 << USED_W) - 64'd1);

  logic [DATA_W-1:0] statusQ;
  logic              trapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      trapQ   <= 1'b0;
    end else begin
      trapQ <= stb.trap;
      if (stb.loadAll) begin
        statusQ <= loadData & LOAD_MASK;
      end else begin
        if (stb.writeCode)  statusQ[TT_MSB:TT_LSB] <= stb.code;
        if (stb.setUnder)   statusQ[UFLAG_BIT]     <= 1'b1;
        if (stb.setInexact) statusQ[IFLAG_BIT]     <= 1'b1;
      end
    end
  end

  assign statusReg = statusQ;
  assign roundMode = statusQ[RM_MSB:RM_LSB];
  assign underEn   = statusQ[UEN_BIT];
  assign inexEn    = statusQ[IEN_BIT];
  assign trapReq   = trapQ;

endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fp_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SWF_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instDone,
  input  logic              isXfer,
  input  logic              excIllegal,
  input  logic              excInvalid,
  input  logic              excDivZero,
  input  logic              excOverflow,
  input  logic              excUnderflow,
  input  logic              excInexact,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] statusReg,
  output logic [1:0]        roundMode,
  output logic              trapReq
);

  fsrStrobe_t stb;
  logic       underEn;
  logic       inexEn;

  fp_status_ctrl u_ctrl (
    .instDone     (instDone),
    .isXfer       (isXfer),
    .loadEn       (loadEn),
    .excIllegal   (excIllegal),
    .excInvalid   (excInvalid),
    .excDivZero   (excDivZero),
    .excOverflow  (excOverflow),
    .excUnderflow (excUnderflow),
    .excInexact   (excInexact),
    .underEn      (underEn),
    .inexEn       (inexEn),
    .stb          (stb)
  );

  fp_status_dp #(.DATA_W(DATA_W), .SWF_W(SWF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .loadData  (loadData),
    .statusReg (statusReg),
    .roundMode (roundMode),
    .underEn   (underEn),
    .inexEn    (inexEn),
    .trapReq   (trapReq)
  );

endmodule

// File: rtl/fp_status_chk.sv
module fp_status_chk
  import fp_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SWF_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              instDone,
  input logic              isXfer,
  input logic              excIllegal,
  input logic              excInvalid,
  input logic              excDivZero,
  input logic              excOverflow,
  input logic              excUnderflow,
  input logic              excInexact,
  input logic              loadEn,
  input logic [DATA_W-1:0] loadData,
  input logic [DATA_W-1:0] statusReg,
  input logic [1:0]        roundMode,
  input logic              trapReq
);

  localparam int USED_W = SWF_LSB + SWF_W;
  localparam logic [DATA_W-1:0] CHK_MASK = DATA_W'((64'd1 << USED_W) - 64'd1);

  logic arith;
  logic hard;
  assign arith = instDone & ~isXfer & ~loadEn;
  assign hard  = excIllegal | excInvalid | excDivZero | excOverflow;

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> statusReg == ($past(loadData) & CHK_MASK));

  assert_clear_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    arith && !hard && !excUnderflow && !excInexact |=> statusReg[TT_MSB:TT_LSB] == 3'b000);

  assert_xfer_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    instDone && isXfer && !loadEn |=> $stable(statusReg) && !trapReq);

  assert_under_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[UFLAG_BIT] && !loadEn |=> statusReg[UFLAG_BIT]);

  assert_under_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    arith && excUnderflow |=> statusReg[UFLAG_BIT]);

  assert_inexact_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[IFLAG_BIT] && !loadEn |=> statusReg[IFLAG_BIT]);

  assert_inexact_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    arith && excInexact && (hard || excUnderflow) |=> $stable(statusReg[IFLAG_BIT]));

  assert_hard_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    arith && hard |=> trapReq);

  assert_trap_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(arith));

  assert_under_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    arith && excUnderflow && !hard && !statusReg[UEN_BIT] |=> !trapReq);

  assert_round_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(roundMode));

  assert_swf_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(statusReg[USED_W-1:SWF_LSB]));

endmodule

bind fp_status_reg fp_status_chk #(.DATA_W(DATA_W), .SWF_W(SWF_W)) i_chk (.*);

// File: tb/test_fp_status_reg.sv
`timescale 1ns/1ps
module test_fp_status_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instDone = 1'b0, isXfer = 1'b0, loadEn = 1'b0;
  logic        excIllegal = 1'b0, excInvalid = 1'b0, excDivZero = 1'b0;
  logic        excOverflow = 1'b0, excUnderflow = 1'b0, excInexact = 1'b0;
  logic [31:0] loadData = '0;
  logic [31:0] statusReg;
  logic [1:0]  roundMode;
  logic        trapReq;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  logic [31:0] mdl = '0;

  typedef struct {
    int          cyc;
    logic [31:0] st;
    logic        tr;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  fp_status_reg i_fp_status_reg (.*);

  // Monitor: compare scheduled expectations at each falling edge
  always @(negedge clk) begin
    cycle++;
    while (expQ.size() > 0 && expQ[0].cyc == cycle) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (statusReg !== it.st || trapReq !== it.tr || roundMode !== it.st[8:7]) begin
        errors++;
        $display("FAIL %s: status=%h trap=%b rm=%b expected status=%h trap=%b rm=%b",
                 it.tag, statusReg, trapReq, roundMode, it.st, it.tr, it.st[8:7]);
      end
    end
  end

  // Driver: one stimulus per cycle, expectation from the requirement model
  // f = {illegal, invalid, divzero, overflow, underflow, inexact}
  task automatic drive(input bit ld, input logic [31:0] d, input bit done,
                       input bit xf, input logic [5:0] f, input string tag);
    logic       other;
    logic [2:0] code;
    logic       expTrap;
    expItem_t   it;
    @(negedge clk); #1;
    loadEn = ld; loadData = d; instDone = done; isXfer = xf;
    {excIllegal, excInvalid, excDivZero, excOverflow, excUnderflow, excInexact} = f;
    expTrap = 1'b0;
    if (ld) begin
      mdl = d & 32'h0000_FFFF;
    end else if (done && !xf) begin
      other = |f[5:1];
      code = f[5] ? 3'b100 : f[4] ? 3'b101 : f[3] ? 3'b011 :
             f[2] ? 3'b010 : f[1] ? 3'b001 : f[0] ? 3'b110 : 3'b000;
      expTrap = (|f[5:2]) | (f[1] & mdl[3]) | (f[0] & ~other & mdl[5]);
      mdl[2:0] = code;
      if (f[1]) mdl[4] = 1'b1;
      if (f[0] && !other) mdl[6] = 1'b1;
    end
    it.cyc = cycle + 1; it.st = mdl; it.tr = expTrap; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    loadEn = 0; instDone = 0; isXfer = 0; loadData = '0;
    {excIllegal, excInvalid, excDivZero, excOverflow, excUnderflow, excInexact} = '0;
  endtask

  task automatic checkReset(input string tag);
    @(negedge clk);
    checks++;
    if (statusReg !== 32'h0 || trapReq !== 1'b0) begin
      errors++;
      $display("FAIL %s: status=%h trap=%b expected status=00000000 trap=0", tag, statusReg, trapReq);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset("R1 reset state");
    #1 rstN = 1'b1;

    drive(0, 0, 1, 0, 6'b000000, "R4 clean completion");
    drive(0, 0, 1, 0, 6'b000100, "R3 R7 overflow traps");
    drive(0, 0, 1, 0, 6'b000000, "R4 code cleared");
    drive(0, 0, 1, 0, 6'b000010, "R5 R8 underflow masked");
    drive(0, 0, 1, 0, 6'b000000, "R5 underflow flag sticky");
    drive(0, 0, 1, 1, 6'b111111, "R4 transfer ignores flags");
    drive(0, 0, 1, 0, 6'b000001, "R6 R8 inexact masked");
    drive(1, 32'h0000_AB28, 0, 0, 6'b000000, "R2 R9 R10 load enables rm=10 swf");
    drive(0, 0, 1, 0, 6'b000010, "R8 underflow enabled traps");
    drive(0, 0, 1, 0, 6'b000001, "R8 inexact enabled traps");
    drive(1, 32'h0000_0020, 0, 0, 6'b000000, "R5 R6 load zero clears flags");
    drive(0, 0, 1, 0, 6'b000101, "R6 inexact with overflow leaves flag");
    drive(0, 0, 1, 0, 6'b111111, "R3 illegal has top priority");
    drive(0, 0, 1, 0, 6'b011000, "R3 invalid over divide by zero");
    drive(0, 0, 1, 0, 6'b001100, "R3 divide by zero over overflow");
    drive(0, 0, 1, 0, 6'b000110, "R3 overflow over underflow");
    drive(0, 0, 1, 0, 6'b000011, "R3 R6 underflow over inexact");
    drive(1, 32'hFFFF_FE40, 1, 0, 6'b001000, "R2 load wins over completion, top zero");
    drive(1, 32'h1234_FE17, 0, 0, 6'b000000, "R9 R10 swf ones, enables clear");
    drive(0, 0, 1, 0, 6'b000010, "R10 swf gives no underflow trap");
    drive(0, 0, 1, 0, 6'b000001, "R10 swf gives no inexact trap");
    drive(0, 0, 1, 0, 6'b010000, "R7 invalid traps with enables clear");
    drive(1, 32'h0000_0180, 0, 0, 6'b000000, "R9 rm=11");
    drive(0, 0, 1, 0, 6'b100000, "R7 illegal traps");
    drive(0, 0, 0, 0, 6'b000000, "R7 trap pulse ends");

    repeat (2) @(negedge clk);
    #1 rstN = 1'b0;
    mdl = '0;
    checkReset("R1 reset mid-run");
    #1 rstN = 1'b1;
    drive(0, 0, 1, 0, 6'b000000, "R1 state after reset");
    repeat (2) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule